// File: doc/BRIEF.md
# Early-Prompt-Late Correlator Bank

This block is the correlation front end of a spread-spectrum tracking channel. Each valid clock it takes one signed intermediate-frequency sample and removes the carrier by multiplying it with a cosine replica sample (in-phase path) and a sine replica sample (quadrature path). Each of the two baseband products is then multiplied by three replica code chips: early, prompt and late. A chip of 1 counts as +1 and a chip of 0 counts as -1, so each multiply is a conditional negation. Six integrate-and-dump accumulators build the correlation sums: in-phase early, prompt and late, and quadrature early, prompt and late.

The replica carrier samples and code chips come from outside the block. So does an epoch strobe that marks the last sample of each code period. The predetection integration length is a count of epochs set on `int_len`. When the programmed number of epochs has been taken, all six sums are latched into the output registers together and a one-cycle valid pulse follows. The accumulators then restart from zero. The prompt pair drives the carrier discriminator. All six sums go to the code discriminator downstream.

The accumulators are sized from the parameters so that the longest integration, taken at the largest product magnitude, cannot overflow. If an epoch runs longer than the nominal number of samples, the accumulators saturate rather than wrap.

Top module: `epl_correlator`

## Requirements
- R1: While reset is asserted, and until the first dump after reset, all six sum outputs read zero and `sum_vld` is low.
- R2: The in-phase baseband value is `if_samp * cos_rep` and the quadrature value is `if_samp * sin_rep`. All three inputs are two's-complement signed.
- R3: For each path, the early, prompt and late arms add the baseband value when `code_e`, `code_p` or `code_l` is 1 respectively, and subtract it when that chip is 0. The output ports map as follows: `sum_ie`/`sum_ip`/`sum_il` take the in-phase arms, and `sum_qe`/`sum_qp`/`sum_ql` take the quadrature arms.
- R4: A clock with `samp_vld` low changes no accumulator and counts no epoch, whatever `if_samp`, the replicas, the chips and `epoch` hold.
- R5: A dump happens on the valid sample that carries the N-th `epoch` strobe of an integration, where N is that integration's length. That final sample is included in the dumped sums.
- R6: On a dump, all six sums are latched together, and `sum_vld` is high for exactly the one cycle after that sample's clock edge. The next integration starts from zero. Back-to-back dumps give back-to-back pulses, each holding only its own samples.
- R7: The length is read from `int_len` on the first valid sample of each integration and is held until that integration dumps. A value of 0 acts as 1, and a value above MAX_EPOCHS acts as MAX_EPOCHS.
- R8: Each accumulator saturates to the range [-2^(ACC_W-1), 2^(ACC_W-1)-1] instead of wrapping, where ACC_W = SAMP_W + CARR_W + clog2(MAX_EPOCHS*EPOCH_SAMP).
- R9: Between dumps, all six sum outputs hold their last latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| samp_vld | input | 1 | Qualifies the sample, replicas, chips and epoch strobe on this clock |
| if_samp | input | SAMP_W | Signed IF sample |
| cos_rep | input | CARR_W | Signed cosine replica carrier sample |
| sin_rep | input | CARR_W | Signed sine replica carrier sample |
| code_e | input | 1 | Early replica chip (1 = +1, 0 = -1) |
| code_p | input | 1 | Prompt replica chip |
| code_l | input | 1 | Late replica chip |
| epoch | input | 1 | This sample is the last of a code epoch |
| int_len | input | clog2(MAX_EPOCHS+1) | Integration length in epochs |
| sum_ie | output | ACC_W | In-phase early sum |
| sum_ip | output | ACC_W | In-phase prompt sum |
| sum_il | output | ACC_W | In-phase late sum |
| sum_qe | output | ACC_W | Quadrature early sum |
| sum_qp | output | ACC_W | Quadrature prompt sum |
| sum_ql | output | ACC_W | Quadrature late sum |
| sum_vld | output | 1 | One-cycle pulse: new sums are on the outputs |

## Verification
The bench builds the block with SAMP_W=4, CARR_W=3, MAX_EPOCHS=4 and EPOCH_SAMP=4, which gives 11-bit accumulators and a 3-bit length field. With these values, one over-long epoch of 40 full-scale products drives the accumulators past both saturation limits. The field can also carry the value 7, which tests clamping to the four-epoch maximum, and the value 0, which tests the one-epoch floor. A small maximum also keeps the epoch counter's wrap and the length capture within a few dozen cycles.

// File: rtl/epl_pkg.sv
package epl_pkg;

  // Arm ordering: in-phase arms first, then quadrature; early, prompt, late in each.
  localparam int NUM_ARMS   = 6;
  localparam int ARMS_PER_PATH = 3;

  function automatic bit arm_is_quad(input int k);
    return k >= ARMS_PER_PATH;
  endfunction

  function automatic int arm_code_idx(input int k);
    return k % ARMS_PER_PATH;
  endfunction

endpackage

// File: rtl/epl_carrier_mix.sv
module epl_carrier_mix #(
  parameter int SAMP_W = 3,
  parameter int CARR_W = 3,
  localparam int MIX_W = SAMP_W + CARR_W
) (
  input  logic signed [SAMP_W-1:0] samp,
  input  logic signed [CARR_W-1:0] cos_rep,
  input  logic signed [CARR_W-1:0] sin_rep,
  output logic signed [MIX_W-1:0]  mix_i,
  output logic signed [MIX_W-1:0]  mix_q
);

  logic signed [MIX_W-1:0] samp_x;
  logic signed [MIX_W-1:0] cos_x;
  logic signed [MIX_W-1:0] sin_x;

  always_comb begin
    samp_x = {{CARR_W{samp[SAMP_W-1]}}, samp};
    cos_x  = {{SAMP_W{cos_rep[CARR_W-1]}}, cos_rep};
    sin_x  = {{SAMP_W{sin_rep[CARR_W-1]}}, sin_rep};
    mix_i  = samp_x * cos_x;
    mix_q  = samp_x * sin_x;
  end

endmodule

// File: rtl/epl_dump_ctrl.sv
module epl_dump_ctrl #(
  parameter int MAX_EPOCHS = 20,
  localparam int LEN_W = $clog2(MAX_EPOCHS + 1),
  localparam int CNT_W = (MAX_EPOCHS > 1) ? $clog2(MAX_EPOCHS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_vld,
  input  logic             epoch,
  input  logic [LEN_W-1:0] int_len,
  output logic             dump
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_EPOCHS);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic             armed_q, armed_d;
  logic [LEN_W-1:0] len_q,   len_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic [LEN_W-1:0] len_clamp;
  logic [LEN_W-1:0] len_eff;
  logic [LEN_W:0]   done_cnt;
  logic             fin;

  // Length select and final-epoch decision
  always_comb begin
    if (int_len == '0)          len_clamp = LEN_ONE;
    else if (int_len > LEN_MAX) len_clamp = LEN_MAX;
    else                        len_clamp = int_len;
    len_eff  = armed_q ? len_clamp : len_q;
    done_cnt = (LEN_W + 1)'(cnt_q) + (LEN_W + 1)'(1);
    fin      = samp_vld && epoch && (done_cnt >= {1'b0, len_eff});
    dump     = fin;
  end

  // Next state
  always_comb begin
    armed_d = armed_q;
    len_d   = len_q;
    cnt_d   = cnt_q;
    if (samp_vld) begin
      armed_d = fin;
      if (armed_q) len_d = len_clamp;
      if (epoch)   cnt_d = fin ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      len_q   <= LEN_ONE;
      cnt_q   <= '0;
    end else if (samp_vld) begin
      armed_q <= armed_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_EPOCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < MAX_EPOCHS); // R5

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (len_q >= LEN_ONE && len_q <= LEN_MAX)); // R7

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |=> ($stable(cnt_q) && $stable(len_q))); // R4

endmodule

// File: rtl/epl_arm.sv
module epl_arm #(
  parameter int IN_W  = 6,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    dump,
  input  logic                    chip,
  input  logic signed [IN_W-1:0]  mix,
  output logic signed [ACC_W-1:0] sum_out
);

  localparam logic signed [ACC_W:0] HI = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] LO = {2'b11, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] out_q, out_d;
  logic signed [ACC_W-1:0] mix_ext;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W:0]   wide;
  logic signed [ACC_W-1:0] acc_nxt;

  // Code wipe-off by conditional negation, then saturating add
  always_comb begin
    mix_ext = {{(ACC_W-IN_W){mix[IN_W-1]}}, mix};
    term    = chip ? mix_ext : -mix_ext;
    wide    = {acc_q[ACC_W-1], acc_q} + {term[ACC_W-1], term};
    if (wide > HI)      acc_nxt = HI[ACC_W-1:0];
    else if (wide < LO) acc_nxt = LO[ACC_W-1:0];
    else                acc_nxt = wide[ACC_W-1:0];
  end

  always_comb begin
    acc_d = acc_q;
    out_d = out_q;
    if (en) begin
      acc_d = dump ? '0 : acc_nxt;
      if (dump) out_d = acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      out_q <= out_d;
    end
  end

  assign sum_out = out_q;

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q)); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dump && acc_q > 0 && term > 0) |=> (acc_q >= $past(acc_q))); // R8

  AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dump && acc_q < 0 && term < 0) |=> (acc_q <= $past(acc_q))); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && dump) |=> $stable(out_q)); // R9

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dump) |=> (acc_q == '0)); // R6

endmodule

// File: rtl/epl_correlator.sv
module epl_correlator #(
  parameter int SAMP_W     = 3,
  parameter int CARR_W     = 3,
  parameter int MAX_EPOCHS = 20,
  parameter int EPOCH_SAMP = 4096,
  localparam int MIX_W = SAMP_W + CARR_W,
  localparam int ACC_W = MIX_W + $clog2(MAX_EPOCHS * EPOCH_SAMP),
  localparam int LEN_W = $clog2(MAX_EPOCHS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    samp_vld,
  input  logic signed [SAMP_W-1:0] if_samp,
  input  logic signed [CARR_W-1:0] cos_rep,
  input  logic signed [CARR_W-1:0] sin_rep,
  input  logic                    code_e,
  input  logic                    code_p,
  input  logic                    code_l,
  input  logic                    epoch,
  input  logic [LEN_W-1:0]        int_len,
  output logic signed [ACC_W-1:0] sum_ie,
  output logic signed [ACC_W-1:0] sum_ip,
  output logic signed [ACC_W-1:0] sum_il,
  output logic signed [ACC_W-1:0] sum_qe,
  output logic signed [ACC_W-1:0] sum_qp,
  output logic signed [ACC_W-1:0] sum_ql,
  output logic                    sum_vld
);

  import epl_pkg::*;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic signed [MIX_W-1:0] mix_i;
  logic signed [MIX_W-1:0] mix_q;
  logic                    dump;
  logic [2:0]              code_vec;
  logic signed [ACC_W-1:0] sums [NUM_ARMS];
  logic                    vld_q, vld_d;

  assign code_vec = {code_l, code_p, code_e};

  epl_carrier_mix #(.SAMP_W(SAMP_W), .CARR_W(CARR_W)) u_mix (
    .samp    (if_samp),
    .cos_rep (cos_rep),
    .sin_rep (sin_rep),
    .mix_i   (mix_i),
    .mix_q   (mix_q)
  );

  epl_dump_ctrl #(.MAX_EPOCHS(MAX_EPOCHS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s),
    .samp_vld (samp_vld),
    .epoch    (epoch),
    .int_len  (int_len),
    .dump     (dump)
  );

  for (genvar k = 0; k < NUM_ARMS; k++) begin : g_arm
    localparam int CI = arm_code_idx(k);
    logic signed [MIX_W-1:0] arm_mix;
    assign arm_mix = arm_is_quad(k) ? mix_q : mix_i;
    epl_arm #(.IN_W(MIX_W), .ACC_W(ACC_W)) u_arm (
      .clk     (clk),
      .rst_n   (rst_s),
      .en      (samp_vld),
      .dump    (dump),
      .chip    (code_vec[CI]),
      .mix     (arm_mix),
      .sum_out (sums[k])
    );
  end

  always_comb vld_d = samp_vld && dump;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign sum_ie  = sums[0];
  assign sum_ip  = sums[1];
  assign sum_il  = sums[2];
  assign sum_qe  = sums[3];
  assign sum_qp  = sums[4];
  assign sum_ql  = sums[5];
  assign sum_vld = vld_q;

  AST_VLD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_s)
    sum_vld |-> $past(samp_vld)); // R6

  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_s)
    !sum_vld |-> ($stable(sum_ip) && $stable(sum_qp))); // R9

  AST_NO_DUMP_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    !samp_vld |=> !sum_vld); // R4

endmodule

// File: tb/sim_epl_correlator.sv
module sim_epl_correlator;

  localparam int SW = 4;
  localparam int CW = 3;
  localparam int ME = 4;
  localparam int ES = 4;
  localparam int AW = 11;
  localparam int LW = 3;
  localparam int HI = 1023;
  localparam int LO = -1024;

  logic clk = 1'b0;
  logic rst_n;
  logic samp_vld;
  logic signed [SW-1:0] if_samp;
  logic signed [CW-1:0] cos_rep, sin_rep;
  logic code_e, code_p, code_l, epoch;
  logic [LW-1:0] int_len;
  logic signed [AW-1:0] sum_ie, sum_ip, sum_il, sum_qe, sum_qp, sum_ql;
  logic sum_vld;

  int checks = 0;
  int fails  = 0;
  int ref_acc [6];
  int last    [6];

  always #10 clk = ~clk;

  epl_correlator #(.SAMP_W(SW), .CARR_W(CW), .MAX_EPOCHS(ME), .EPOCH_SAMP(ES)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .if_samp(if_samp),
    .cos_rep(cos_rep), .sin_rep(sin_rep), .code_e(code_e), .code_p(code_p),
    .code_l(code_l), .epoch(epoch), .int_len(int_len),
    .sum_ie(sum_ie), .sum_ip(sum_ip), .sum_il(sum_il),
    .sum_qe(sum_qe), .sum_qp(sum_qp), .sum_ql(sum_ql), .sum_vld(sum_vld)
  );

  function automatic int sat(input int v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  function automatic int dut_sum(input int k);
    case (k)
      0: return int'(sum_ie);
      1: return int'(sum_ip);
      2: return int'(sum_il);
      3: return int'(sum_qe);
      4: return int'(sum_qp);
      default: return int'(sum_ql);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, let the posedge pass, check at next negedge.
  task automatic step(input bit v, input int ifs, input int c, input int s,
                      input bit e, input bit p, input bit l, input bit ep,
                      input bit exp_dump, input string req);
    bit chips [3];
    samp_vld = v; if_samp = SW'(ifs); cos_rep = CW'(c); sin_rep = CW'(s);
    code_e = e; code_p = p; code_l = l; epoch = ep;
    chips[0] = e; chips[1] = p; chips[2] = l;
    if (v) begin
      for (int k = 0; k < 6; k++) begin
        int base;
        base = (k < 3) ? ifs * c : ifs * s;
        ref_acc[k] = sat(ref_acc[k] + (chips[k % 3] ? base : -base));
      end
    end
    @(negedge clk);
    check(sum_vld == exp_dump, req, "sum_vld", int'(sum_vld), int'(exp_dump));
    if (exp_dump) begin
      for (int k = 0; k < 6; k++) begin
        check(dut_sum(k) == ref_acc[k], req, $sformatf("dumped sum arm %0d", k),
              dut_sum(k), ref_acc[k]);
        last[k] = ref_acc[k];
        ref_acc[k] = 0;
      end
    end else begin
      for (int k = 0; k < 6; k++)
        if (dut_sum(k) != last[k])
          check(1'b0, "R9", $sformatf("held sum arm %0d", k), dut_sum(k), last[k]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; samp_vld = 0; if_samp = '0; cos_rep = '0; sin_rep = '0;
    code_e = 0; code_p = 0; code_l = 0; epoch = 0; int_len = 3'd1;
    for (int k = 0; k < 6; k++) begin ref_acc[k] = 0; last[k] = 0; end
    repeat (3) @(negedge clk);
    check(sum_vld == 1'b0, "R1", "vld in reset", int'(sum_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++)
      check(dut_sum(k) == 0, "R1", $sformatf("sum arm %0d after reset", k), dut_sum(k), 0);
    check(sum_vld == 1'b0, "R1", "vld after reset", int'(sum_vld), 0);
  endtask

  // R2 R3 R5 R6: one-epoch integration, mixed chips and signs
  task automatic t_basic();
    int_len = 3'd1;
    step(1,  3,  2, -1, 1, 0, 1, 0, 0, "R2");
    step(1, -5,  1,  3, 0, 0, 1, 0, 0, "R3");
    step(1,  7, -4,  2, 1, 1, 0, 0, 0, "R3");
    step(1, -8, -3, -4, 0, 1, 1, 1, 1, "R5");
    step(0,  0,  0,  0, 0, 0, 0, 0, 0, "R6");
  endtask

  // R4: invalid clocks with garbage and epoch strobes are ignored
  task automatic t_idle();
    int_len = 3'd2;
    step(1,  2,  3,  1, 1, 1, 1, 1, 0, "R4");
    step(0,  7,  3,  3, 1, 1, 1, 1, 0, "R4");
    step(0, -8, -4, -4, 0, 0, 0, 1, 0, "R4");
    step(1, -1,  2, -2, 0, 1, 0, 0, 0, "R4");
    step(0,  6,  1,  1, 1, 0, 1, 1, 0, "R4");
    step(1,  4, -1,  3, 1, 0, 0, 1, 1, "R5");
  endtask

  // R7: length captured at integration start, clamped at both ends
  task automatic t_len();
    int_len = 3'd3;
    step(1, 1, 1, 1, 1, 1, 1, 1, 0, "R7");
    int_len = 3'd1;
    step(1, 2, 1, 2, 1, 0, 1, 1, 0, "R7");
    step(1, 3, 2, 1, 0, 1, 1, 1, 1, "R7");
    step(1, 1, 3, 3, 1, 1, 0, 1, 1, "R7");
    int_len = 3'd0;
    step(1, -2, 1, 1, 1, 1, 1, 1, 1, "R7");
    int_len = 3'd7;
    step(1, 5, 1, -1, 1, 1, 1, 1, 0, "R7");
    step(1, 5, 1, -1, 1, 1, 1, 1, 0, "R7");
    step(1, 5, 1, -1, 0, 1, 1, 1, 0, "R7");
    step(1, 5, 1, -1, 0, 0, 1, 1, 1, "R7");
  endtask

  // R8: one over-long epoch of full-scale products
  task automatic t_sat();
    int_len = 3'd1;
    for (int i = 0; i < 39; i++)
      step(1, -8, -4, -4, 1, 0, 1, 0, 0, "R8");
    step(1, -8, -4, -4, 1, 0, 1, 1, 1, "R8");
    check(int'(sum_ie) == HI, "R8", "positive clamp", int'(sum_ie), HI);
    check(int'(sum_ip) == LO, "R8", "negative clamp", int'(sum_ip), LO);
  endtask

  // R6: back-to-back dumps, each with only its own sample
  task automatic t_b2b();
    int_len = 3'd1;
    step(1,  3,  3, -2, 1, 0, 1, 1, 1, "R6");
    step(1, -4,  2,  1, 0, 1, 1, 1, 1, "R6");
    step(1,  6, -1,  3, 1, 1, 0, 1, 1, "R6");
    step(0,  0,  0,  0, 0, 0, 0, 0, 0, "R6");
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_idle();
    t_len();
    t_sat();
    t_b2b();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule